// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 16-bit virtual address into a physical address through a small table of segment descriptors kept in registers next to the datapath. The two most significant address bits pick a descriptor; the fourteen bits below them form an offset. Each descriptor holds a base address, a limit and a valid flag. The offset is checked against the limit, and when the access is allowed the base and offset are added to form the physical address.

Software fills the table through a single write port (enable, index, base, limit, valid). A translation is requested by raising `req_valid` with an address; one clock later `rsp_valid` rises together with the registered physical address, an error flag and a two-bit cause. A faulting access never leaks an address: the physical address reads zero whenever the error flag is set. After reset every descriptor is marked invalid, so every access faults until the table has been loaded.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0 and every descriptor is invalid, so any request before a table write returns error with cause 1.
- R2: The descriptor index is virtual address bits [15:14]; the offset is bits [13:0].
- R3: For a valid descriptor with offset < limit, `rsp_paddr` = (base + offset) modulo 2^16, `rsp_err` = 0 and `rsp_cause` = 0.
- R4: For a valid descriptor with offset >= limit, `rsp_err` = 1, `rsp_cause` = 2 and `rsp_paddr` = 0.
- R5: For an invalid descriptor, `rsp_err` = 1, `rsp_cause` = 1 and `rsp_paddr` = 0, whatever the offset and limit.
- R6: `rsp_valid` is 1 in the cycle after a cycle with `req_valid` = 1 and 0 otherwise.
- R7: A table write changes the descriptor from the next clock edge; a request in the same cycle as a write to its descriptor is translated with the old contents.
- R8: `rsp_err` is 1 exactly when `rsp_cause` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one table descriptor |
| wr_idx | input | 2 | Descriptor index to write |
| wr_base | input | 16 | Base address written |
| wr_limit | input | 15 | Segment length written (offsets below it are legal) |
| wr_valid | input | 1 | Valid flag written |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_paddr | output | 16 | Physical address, zero on error |
| rsp_err | output | 1 | Access fault |
| rsp_cause | output | 2 | 0 none, 1 invalid descriptor, 2 limit overrun |

## Verification
A table write and a translation through the same descriptor can land in the same cycle. The bench provokes this by raising `wr_en` and `req_valid` on one clock edge, targeting one descriptor with contents that give a clearly different answer, and expects the response to reflect the old descriptor; a second request right after must show the new one. The rest is a sweep of offsets across all four descriptors, including limit-1, limit and limit+1, with expected values computed from a bench-side copy of the table.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      FAULT_NONE   = 2'd0,
      FAULT_BADSEG = 2'd1,
      FAULT_RANGE  = 2'd2
   } fault_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_BITS = 2,
   parameter int PA_W     = 16,
   parameter int LIM_W    = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEG_BITS-1:0] wr_idx,
   input  logic [PA_W-1:0]     wr_base,
   input  logic [LIM_W-1:0]    wr_limit,
   input  logic                wr_valid,
   input  logic [SEG_BITS-1:0] rd_idx,
   output logic [PA_W-1:0]     rd_base,
   output logic [LIM_W-1:0]    rd_limit,
   output logic                rd_valid
);
   localparam int NUM_SEGS = 1 << SEG_BITS;

   logic [PA_W-1:0]  base_q  [NUM_SEGS];
   logic [LIM_W-1:0] limit_q [NUM_SEGS];
   logic [NUM_SEGS-1:0] valid_q;

   for (genvar e = 0; e < NUM_SEGS; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == SEG_BITS'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            base_q[e]  <= '0;
            limit_q[e] <= '0;
         end else if (hit) begin
            valid_q[e] <= wr_valid;
            base_q[e]  <= wr_base;
            limit_q[e] <= wr_limit;
         end
      end
   end

   assign rd_base  = base_q[rd_idx];
   assign rd_limit = limit_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];

   // R7: a write lands in the addressed entry on the following edge
   p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)) &&
                (base_q[$past(wr_idx)] == $past(wr_base)));
endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int OFF_W = 14,
   parameter int PA_W  = 16,
   parameter int LIM_W = 15
) (
   input  logic [OFF_W-1:0] offset,
   input  logic [PA_W-1:0]  base,
   input  logic [LIM_W-1:0] limit,
   input  logic             valid,
   output logic [PA_W-1:0]  paddr,
   output fault_e           fault
);
   logic [LIM_W-1:0] off_ext;
   logic [PA_W-1:0]  sum;
   logic             over;

   assign off_ext = LIM_W'(offset);
   assign over    = (off_ext >= limit);
   assign sum     = base + PA_W'(offset);

   always_comb begin
      if (!valid) begin
         fault = FAULT_BADSEG;
         paddr = '0;
      end else if (over) begin
         fault = FAULT_RANGE;
         paddr = '0;
      end else begin
         fault = FAULT_NONE;
         paddr = sum;
      end
   end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int VA_W     = 16,
   parameter int SEG_BITS = 2,
   parameter int PA_W     = 16,
   localparam int OFF_W   = VA_W - SEG_BITS,
   localparam int LIM_W   = OFF_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEG_BITS-1:0] wr_idx,
   input  logic [PA_W-1:0]     wr_base,
   input  logic [LIM_W-1:0]    wr_limit,
   input  logic                wr_valid,
   input  logic                req_valid,
   input  logic [VA_W-1:0]     req_vaddr,
   output logic                rsp_valid,
   output logic [PA_W-1:0]     rsp_paddr,
   output logic                rsp_err,
   output logic [1:0]          rsp_cause
);
   if (SEG_BITS < 1 || SEG_BITS > 3) begin : g_bad_segs
      $error("SEG_BITS must give between 2 and 8 descriptors");
   end
   if (OFF_W < 1) begin : g_bad_va
      $error("VA_W must exceed SEG_BITS");
   end
   if (PA_W < OFF_W) begin : g_bad_pa
      $error("PA_W must hold a full offset");
   end

   logic [SEG_BITS-1:0] seg;
   logic [OFF_W-1:0]    offset;
   logic [PA_W-1:0]     t_base;
   logic [LIM_W-1:0]    t_limit;
   logic                t_valid;
   logic [PA_W-1:0]     c_paddr;
   fault_e              c_fault;

   assign seg    = req_vaddr[VA_W-1 -: SEG_BITS];
   assign offset = req_vaddr[OFF_W-1:0];

   seg_table #(.SEG_BITS(SEG_BITS), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
      .wr_limit(wr_limit), .wr_valid(wr_valid),
      .rd_idx(seg), .rd_base(t_base), .rd_limit(t_limit), .rd_valid(t_valid)
   );

   seg_check #(.OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_check (
      .offset(offset), .base(t_base), .limit(t_limit), .valid(t_valid),
      .paddr(c_paddr), .fault(c_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_err   <= 1'b0;
         rsp_cause <= 2'd0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_paddr <= c_paddr;
            rsp_err   <= (c_fault != FAULT_NONE);
            rsp_cause <= c_fault;
         end
      end
   end

   // R6: response strobe follows a request by exactly one cycle
   p_rsp_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_no_rsp_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R4 / R5: a faulting response carries no address
   p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_paddr == '0));
   // R8: flag and cause agree
   p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_err == (rsp_cause != 2'd0)));
   // R5: invalid descriptor at request time gives cause 1
   p_badseg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !t_valid) |=> (rsp_cause == 2'd1));
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [15:0] wr_base = '0;
   logic [14:0] wr_limit = '0;
   logic        wr_valid = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_vaddr = '0;
   logic        rsp_valid;
   logic [15:0] rsp_paddr;
   logic        rsp_err;
   logic [1:0]  rsp_cause;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [15:0] m_base  [4];
   logic [14:0] m_limit [4];
   logic        m_valid [4];

   always #2 clk = ~clk;

   seg_xlate uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_base(wr_base), .wr_limit(wr_limit), .wr_valid(wr_valid),
      .req_valid(req_valid), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_err(rsp_err), .rsp_cause(rsp_cause)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_entry(input int idx, input logic [15:0] b,
                              input logic [14:0] l, input logic v);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 2'(idx); wr_base = b; wr_limit = l; wr_valid = v;
      @(negedge clk);
      wr_en = 1'b0;
      m_base[idx] = b; m_limit[idx] = l; m_valid[idx] = v;
   endtask

   // expected result from the bench model
   task automatic expect_of(input logic [15:0] va, output logic [15:0] pa,
                            output logic [1:0] cause);
      int s;
      logic [13:0] off;
      s = int'(va[15:14]);
      off = va[13:0];
      if (!m_valid[s]) begin
         pa = 16'h0; cause = 2'd1;
      end else if ({1'b0, off} >= m_limit[s]) begin
         pa = 16'h0; cause = 2'd2;
      end else begin
         pa = m_base[s] + {2'b00, off}; cause = 2'd0;
      end
   endtask

   task automatic xlate(input logic [15:0] va, input string req);
      logic [15:0] pa;
      logic [1:0]  c;
      expect_of(va, pa, c);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      chk({req, " R6 rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({req, " paddr"}, 32'(rsp_paddr), 32'(pa));
      chk({req, " cause"}, 32'(rsp_cause), 32'(c));
      chk({req, " R8 err"}, 32'(rsp_err), 32'(c != 2'd0));
   endtask

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      // R1: every descriptor faults before loading
      for (int s = 0; s < 4; s++)
         xlate({2'(s), 14'h0010}, "R1 unloaded");
      @(negedge clk);
      chk("R6 idle rsp_valid", 32'(rsp_valid), 32'd0);

      write_entry(0, 16'h4000, 15'h0800, 1'b1);
      write_entry(1, 16'h4800, 15'h1400, 1'b1);
      write_entry(2, 16'hF000, 15'h1000, 1'b1);
      write_entry(3, 16'h0000, 15'h3000, 1'b1);

      // R2 R3 R4: offset sweep on every descriptor
      for (int s = 0; s < 4; s++) begin
         for (int o = 0; o < 16384; o += 128)
            xlate({2'(s), 14'(o)}, "R2/R3/R4 sweep");
         xlate({2'(s), 14'(m_limit[s] - 15'd1)}, "R3 limit-1");
         xlate({2'(s), 14'(m_limit[s])}, "R4 at limit");
         xlate({2'(s), 14'(m_limit[s] + 15'd1)}, "R4 limit+1");
         xlate({2'(s), 14'h3FFF}, "R4 top offset");
      end

      // R3: wraparound of base + offset
      write_entry(1, 16'hFF00, 15'h4000, 1'b1);
      xlate(16'h4200, "R3 wrap");
      chk("R3 wrap value", 32'(rsp_paddr), 32'h0100);
      xlate(16'h7FFF, "R3 full-length segment");

      // R5: invalid wins over a limit overrun
      write_entry(3, 16'h1234, 15'h0000, 1'b0);
      xlate(16'hC000, "R5 invalid low");
      xlate(16'hFFFF, "R5 invalid high");
      chk("R5 cause value", 32'(rsp_cause), 32'd1);
      xlate(16'h0100, "R5 neighbour still valid");

      // R7: write and request through the same descriptor in one cycle
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 2'd2; wr_base = 16'h2000; wr_limit = 15'h0100; wr_valid = 1'b1;
      req_valid = 1'b1; req_vaddr = 16'h8200;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      chk("R7 same-cycle rsp_valid", 32'(rsp_valid), 32'd1);
      chk("R7 same-cycle old paddr", 32'(rsp_paddr), 32'hF200);
      chk("R7 same-cycle old cause", 32'(rsp_cause), 32'd0);
      m_base[2] = 16'h2000; m_limit[2] = 15'h0100; m_valid[2] = 1'b1;
      xlate(16'h8200, "R7 new contents overrun");
      xlate(16'h80FF, "R7 new contents in range");

      // R7: invalidating write in the same cycle as a request
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 2'd0; wr_base = 16'h0; wr_limit = 15'h0; wr_valid = 1'b0;
      req_valid = 1'b1; req_vaddr = 16'h0004;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      chk("R7 invalidate old paddr", 32'(rsp_paddr), 32'h4004);
      m_valid[0] = 1'b0; m_base[0] = 16'h0; m_limit[0] = 15'h0;
      xlate(16'h0004, "R7 after invalidate");

      // R1: reset clears the table again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) m_valid[i] = 1'b0;
      xlate(16'h8010, "R1 after second reset");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule